// File: doc/BRIEF.md
# I2C Bus Clear Controller

This block frees an I2C bus that a slave holds hung after a transfer was cut off in the middle of a byte, for example by a reset of the master. It sits beside the normal master logic and owns the two open-drain lines only while it runs. It reads SCL and SDA through synchronizers and drives them only through drive-low enables. When it is triggered, it first checks the lines. If SDA is held low while SCL is free, it sends single clock pulses. After each pulse it checks whether the slave has let go of SDA, and it stops at the first pulse after which SDA reads high.

When SDA is free, the block places a STOP condition on the bus: it pulls SDA low while SCL is high, then releases it. Both lines then rest high, so every slave sees the next START. A recovery starts from a one-cycle request, or from a watchdog that sees the bus-busy indication stay set longer than a programmable number of cycles. Two failure flags tell the system that only a device reset or a power cycle can help. One means SCL is stuck low. The other means SDA stayed low through the whole pulse budget.

Top module: `bus_unhang`

## Requirements
- R1: The block never drives a line high. `scl_oe` and `sda_oe` are drive-low enables, both are 0 out of reset and whenever `busy` is 0, and the two are never 1 together.
- R2: A one-cycle `start_req` while idle sets `busy` from the next cycle on. In that same cycle `done` becomes 0 and `pulse_count` becomes 0, and both failure flags are cleared.
- R3: Clock pulses are sent only while the synchronized SDA reads low. SDA is sampled at the end of each released-high phase, pulsing stops at the first sample that reads high, and `pulse_count` equals the number of pulses sent. If SDA is already high at the start, no pulse is sent.
- R4: Each pulse drives `scl_oe` high for exactly `max(half_div,1)` clock cycles. After SCL is seen high, the block waits the same number of cycles before it samples SDA.
- R5: At most MAX_PULSES (default 9) pulses are sent. If SDA is still low after the last one, the block stops with `sda_stuck`=1 and `pulse_count`=MAX_PULSES, and sends no STOP.
- R6: If SCL reads low when a recovery starts, no pulse is sent. The block ends at once with `scl_stuck`=1 and `pulse_count`=0.
- R7: After it releases SCL, the block waits for SCL to read high. If SCL stays low for RISE_LIMIT cycles, it ends with `scl_stuck`=1, both enables at 0, and the count of completed pulses only.
- R8: Once SDA reads high, the block asserts `sda_oe` while SCL is released, for one half-period, and then releases it. This makes a STOP. When `done` rises, both enables are 0.
- R9: When idle, the recovery starts by itself once `bus_busy` has been sampled high on `busy_tmo` consecutive cycles. A low cycle restarts that count, and `busy_tmo`=0 turns the watchdog off.
- R10: `done`, `pulse_count` and both flags keep their values until the next start. A `start_req` while `busy` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_req | input | 1 | One-cycle request to start a recovery |
| bus_busy | input | 1 | Bus-busy indication watched by the watchdog |
| half_div | input | DIV_W | Half-period length in clock cycles (0 is treated as 1) |
| busy_tmo | input | TMO_W | Busy timeout in cycles, 0 disables it |
| scl_in | input | 1 | SCL line level, asynchronous |
| sda_in | input | 1 | SDA line level, asynchronous |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| busy | output | 1 | Recovery in progress |
| done | output | 1 | Last recovery finished, held until next start |
| pulse_count | output | CNT_W | Clock pulses sent in the last recovery (0 to MAX_PULSES) |
| scl_stuck | output | 1 | SCL held low, device reset needed |
| sda_stuck | output | 1 | SDA held low past the pulse budget, device reset needed |

## Verification
The bench builds the block with DIV_W=8, TMO_W=8 and RISE_LIMIT=64, and keeps MAX_PULSES at 9. It runs with `half_div`=5 and `busy_tmo`=20. A short rise limit lets the missing-SCL-rise failure be reached in tens of cycles instead of thousands. The small half-period keeps a full nine-pulse budget, and a slave that holds SDA past it, within a few hundred cycles. A modeled slave holds SDA for a chosen number of SCL rises, so counts of 0, 1, 3, 8, 9 and beyond the budget are all reachable.

// File: rtl/bus_unhang_pkg.sv
package bus_unhang_pkg;

  typedef enum logic [2:0] {
    BC_IDLE,
    BC_CHECK,
    BC_LOW,
    BC_REL,
    BC_HIGH,
    BC_STP_LOW,
    BC_STP_REL
  } bc_state_e;

  // a zero half-period would stall the timer, so it is raised to one cycle
  function automatic logic [31:0] floor_one(input logic [31:0] v);
    return (v == 32'd0) ? 32'd1 : v;
  endfunction

  // true when the pulse about to complete uses up the budget
  function automatic logic budget_spent(input logic [31:0] sent, input logic [31:0] max_p);
    return (sent + 32'd1) >= max_p;
  endfunction

endpackage

// File: rtl/line_sync.sv
module line_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], d_async[b]};
    end
    assign q_sync[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/phase_timer.sv
module phase_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] limit,
  output logic         expire
);
  logic [W-1:0] cnt;

  assign expire = run && (cnt == limit - W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (!run || expire)   cnt <= '0;
    else                       cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/busy_watchdog.sv
module busy_watchdog #(
  parameter int TMO_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_busy,
  input  logic             hold,
  input  logic [TMO_W-1:0] tmo,
  output logic             fire
);
  logic [TMO_W-1:0] cnt;
  logic             armed;

  assign armed = (tmo != '0);
  assign fire  = armed && bus_busy && !hold && (cnt == tmo - TMO_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           cnt <= '0;
    else if (!bus_busy || hold || fire)   cnt <= '0;
    else                                  cnt <= cnt + TMO_W'(1);
  end
endmodule

// File: rtl/bus_unhang.sv
module bus_unhang #(
  parameter int DIV_W       = 16,
  parameter int TMO_W       = 24,
  parameter int MAX_PULSES  = 9,
  parameter int RISE_LIMIT  = 4096,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(MAX_PULSES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic             bus_busy,
  input  logic [DIV_W-1:0] half_div,
  input  logic [TMO_W-1:0] busy_tmo,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             scl_oe,
  output logic             sda_oe,
  output logic             busy,
  output logic             done,
  output logic [CNT_W-1:0] pulse_count,
  output logic             scl_stuck,
  output logic             sda_stuck
);
  import bus_unhang_pkg::*;

  localparam int RISE_W = $clog2(RISE_LIMIT + 1);

  bc_state_e        state;
  logic             scl_s, sda_s;
  logic             wd_fire;
  logic             launch;
  logic             half_run, half_exp;
  logic             rise_run, rise_exp;
  logic [DIV_W-1:0] half_lim;
  logic             last_pulse;

  line_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async ({scl_in, sda_in}),
    .q_sync  ({scl_s, sda_s})
  );

  busy_watchdog #(.TMO_W(TMO_W)) u_wdog (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_busy (bus_busy),
    .hold     (busy),
    .tmo      (busy_tmo),
    .fire     (wd_fire)
  );

  assign half_lim = DIV_W'(floor_one(32'(half_div)));
  assign half_run = (state == BC_LOW) || (state == BC_HIGH) ||
                    (state == BC_STP_LOW) || (state == BC_STP_REL);
  assign rise_run = (state == BC_REL);

  phase_timer #(.W(DIV_W)) u_half (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (half_run),
    .limit  (half_lim),
    .expire (half_exp)
  );

  phase_timer #(.W(RISE_W)) u_rise (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (rise_run),
    .limit  (RISE_W'(RISE_LIMIT)),
    .expire (rise_exp)
  );

  assign busy       = (state != BC_IDLE);
  assign launch     = !busy && (start_req || wd_fire);
  assign last_pulse = budget_spent(32'(pulse_count), 32'(MAX_PULSES));
  assign scl_oe     = (state == BC_LOW);
  assign sda_oe     = (state == BC_STP_LOW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= BC_IDLE;
      done        <= 1'b0;
      pulse_count <= '0;
      scl_stuck   <= 1'b0;
      sda_stuck   <= 1'b0;
    end else begin
      unique case (state)
        BC_IDLE: if (launch) begin
          state       <= BC_CHECK;
          done        <= 1'b0;
          pulse_count <= '0;
          scl_stuck   <= 1'b0;
          sda_stuck   <= 1'b0;
        end
        BC_CHECK: begin
          if (!scl_s) begin
            scl_stuck <= 1'b1;
            done      <= 1'b1;
            state     <= BC_IDLE;
          end else if (sda_s) begin
            state <= BC_STP_LOW;
          end else begin
            state <= BC_LOW;
          end
        end
        BC_LOW: if (half_exp) state <= BC_REL;
        BC_REL: begin
          if (scl_s) begin
            state <= BC_HIGH;
          end else if (rise_exp) begin
            scl_stuck <= 1'b1;
            done      <= 1'b1;
            state     <= BC_IDLE;
          end
        end
        BC_HIGH: if (half_exp) begin
          pulse_count <= pulse_count + CNT_W'(1);
          if (sda_s) begin
            state <= BC_STP_LOW;
          end else if (last_pulse) begin
            sda_stuck <= 1'b1;
            done      <= 1'b1;
            state     <= BC_IDLE;
          end else begin
            state <= BC_LOW;
          end
        end
        BC_STP_LOW: if (half_exp) state <= BC_STP_REL;
        BC_STP_REL: if (half_exp) begin
          done  <= 1'b1;
          state <= BC_IDLE;
        end
        default: state <= BC_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bus_unhang_chk.sv
module bus_unhang_chk #(
  parameter int DIV_W      = 16,
  parameter int CNT_W      = 4,
  parameter int MAX_PULSES = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_req,
  input logic             busy,
  input logic             done,
  input logic             scl_oe,
  input logic             sda_oe,
  input logic             scl_stuck,
  input logic             sda_stuck,
  input logic [CNT_W-1:0] pulse_count,
  input logic             launch,
  input logic [DIV_W-1:0] half_lim
);
  logic [31:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      low_run <= '0;
    else if (scl_oe) low_run <= low_run + 32'd1;
    else             low_run <= '0;
  end

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_oe && !sda_oe)); // R1

  AST_NO_DUAL_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(scl_oe && sda_oe)); // R1

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start_req) |=> (busy && !done && pulse_count == '0)); // R2

  AST_LOW_PHASE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_oe) |-> (low_run == 32'(half_lim))); // R4

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    32'(pulse_count) <= 32'(MAX_PULSES)); // R5

  AST_SDA_STUCK_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_stuck) |-> (32'(pulse_count) == 32'(MAX_PULSES))); // R5

  AST_ONE_FAILURE: assert property (@(posedge clk) disable iff (!rst_n)
    !(scl_stuck && sda_stuck)); // R6

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R10

  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !launch) |=> ($stable(done) && $stable(pulse_count) &&
                            $stable(scl_stuck) && $stable(sda_stuck))); // R10
endmodule

bind bus_unhang bus_unhang_chk #(
  .DIV_W(DIV_W), .CNT_W(CNT_W), .MAX_PULSES(MAX_PULSES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start_req(start_req), .busy(busy), .done(done),
  .scl_oe(scl_oe), .sda_oe(sda_oe), .scl_stuck(scl_stuck), .sda_stuck(sda_stuck),
  .pulse_count(pulse_count), .launch(launch), .half_lim(half_lim)
);

// File: tb/bus_unhang_test.sv
`timescale 1ns/1ps
module bus_unhang_test;
  localparam int DIV_W = 8;
  localparam int TMO_W = 8;
  localparam int MAXP  = 9;
  localparam int RISEL = 64;
  localparam int CW    = $clog2(MAXP + 1);
  localparam int HALF  = 5;

  // {slave hold rises[4:0], expected count[3:0], expected sda_stuck}
  localparam logic [9:0] TBL [6] = '{
    {5'd0,  4'd0, 1'b0},
    {5'd1,  4'd1, 1'b0},
    {5'd3,  4'd3, 1'b0},
    {5'd8,  4'd8, 1'b0},
    {5'd9,  4'd9, 1'b0},
    {5'd12, 4'd9, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_req = 1'b0;
  logic bus_busy = 1'b0;
  logic [DIV_W-1:0] half_div = DIV_W'(HALF);
  logic [TMO_W-1:0] busy_tmo = '0;
  logic scl_oe, sda_oe, busy, done, scl_stuck, sda_stuck;
  logic [CW-1:0] pulse_count;
  logic force_scl = 1'b0;

  int checks = 0, errors = 0, cycles = 0;
  int hold_req = 0, rise_base = 0, scl_rises = 0;
  int oe_pulses = 0, pulse_base = 0;
  int stops = 0, stop_base = 0;
  int oe_run = 0, last_run = 0;

  wire scl_line = !(scl_oe || force_scl);
  wire slave_low = (scl_rises - rise_base) < hold_req;
  wire sda_line = !(sda_oe || slave_low);

  always #2 clk = ~clk;

  bus_unhang #(.DIV_W(DIV_W), .TMO_W(TMO_W), .MAX_PULSES(MAXP), .RISE_LIMIT(RISEL)) uut (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .bus_busy(bus_busy),
    .half_div(half_div), .busy_tmo(busy_tmo), .scl_in(scl_line), .sda_in(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .done(done),
    .pulse_count(pulse_count), .scl_stuck(scl_stuck), .sda_stuck(sda_stuck)
  );

  always @(posedge scl_line) scl_rises <= scl_rises + 1;
  always @(posedge scl_oe) if (rst_n) oe_pulses <= oe_pulses + 1;
  always @(negedge sda_oe) if (rst_n && scl_line) stops <= stops + 1;
  always @(negedge clk) begin
    cycles <= cycles + 1;
    if (scl_oe) oe_run <= oe_run + 1;
    else if (oe_run != 0) begin last_run <= oe_run; oe_run <= 0; end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic arm(input int hold);
    hold_req = hold;
    rise_base = scl_rises;
    pulse_base = oe_pulses;
    stop_base = stops;
  endtask

  task automatic kick();
    @(negedge clk) start_req = 1'b1;
    @(negedge clk) start_req = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 3000 && !done; i++) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // reset state, R1
    chk("R1 scl_oe reset", int'(scl_oe), 0);
    chk("R1 sda_oe reset", int'(sda_oe), 0);
    chk("R10 done reset", int'(done), 0);
    chk("R10 busy reset", int'(busy), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // table walk: R3, R5, R8
    for (int k = 0; k < 6; k++) begin
      arm(int'(TBL[k][9:5]));
      kick();
      chk("R2 busy after request", int'(busy), 1);
      chk("R2 done cleared", int'(done), 0);
      wait_done();
      chk("R3 pulse_count", int'(pulse_count), int'(TBL[k][4:1]));
      chk("R3 pulses on line", oe_pulses - pulse_base, int'(TBL[k][4:1]));
      chk("R5 sda_stuck", int'(sda_stuck), int'(TBL[k][0]));
      chk("R8 stop issued", stops - stop_base, TBL[k][0] ? 0 : 1);
      chk("R8 lines released", int'(scl_oe | sda_oe), 0);
      chk("R6 no scl_stuck", int'(scl_stuck), 0);
      if (TBL[k][4:1] != 0) chk("R4 low phase length", last_run, HALF);
      repeat (3) @(negedge clk);
    end

    // R10: status held, request while busy ignored
    arm(4);
    kick();
    repeat (6) @(negedge clk);
    kick();
    wait_done();
    chk("R10 count with ignored request", int'(pulse_count), 4);
    repeat (20) @(negedge clk);
    chk("R10 no restart", int'(busy), 0);
    chk("R10 done held", int'(done), 1);
    chk("R10 count held", int'(pulse_count), 4);

    // R6: SCL low at start
    force_scl = 1'b1;
    arm(3);
    repeat (5) @(negedge clk);
    kick();
    wait_done();
    chk("R6 scl_stuck", int'(scl_stuck), 1);
    chk("R6 pulse_count", int'(pulse_count), 0);
    chk("R6 no pulses", oe_pulses - pulse_base, 0);
    force_scl = 1'b0;
    repeat (5) @(negedge clk);

    // R7: SCL held low by another party during the first pulse
    arm(5);
    kick();
    for (int i = 0; i < 100 && !scl_oe; i++) @(negedge clk);
    force_scl = 1'b1;
    wait_done();
    chk("R7 scl_stuck", int'(scl_stuck), 1);
    chk("R7 pulse_count", int'(pulse_count), 0);
    chk("R7 scl released", int'(scl_oe), 0);
    chk("R7 sda released", int'(sda_oe), 0);
    force_scl = 1'b0;
    repeat (5) @(negedge clk);

    // R9: watchdog start
    busy_tmo = TMO_W'(20);
    arm(2);
    bus_busy = 1'b1;
    repeat (10) @(negedge clk);
    bus_busy = 1'b0;
    @(negedge clk);
    bus_busy = 1'b1;
    repeat (10) @(negedge clk);
    chk("R9 gap restarts count", int'(busy), 0);
    repeat (9) @(negedge clk);
    chk("R9 not yet started", int'(busy), 0);
    @(negedge clk);
    chk("R9 started on timeout", int'(busy), 1);
    bus_busy = 1'b0;
    wait_done();
    chk("R9 count via watchdog", int'(pulse_count), 2);

    // R9: zero timeout disables the watchdog
    busy_tmo = '0;
    bus_busy = 1'b1;
    repeat (100) @(negedge clk);
    chk("R9 disabled watchdog", int'(busy), 0);
    bus_busy = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule